// File: doc/BRIEF.md
# Colour Matrix with Post-Offset

This block multiplies each incoming RGB pixel by a programmable 3×3 colour matrix and then adds a per-channel post-offset. Each output channel is the weighted sum of all three input channels, and the result is clamped to the output code range. Pixels enter and leave on valid/ready handshakes with 10-bit channels. The pipeline has a fixed depth of three stages and stalls as a whole when the consumer holds back.

Coefficients are written as 64-bit sign-magnitude values with 32 fraction bits. An on-chip converter rounds each value, saturates it and stores it as a 16-bit sign-magnitude word with 3 integer bits and 12 fraction bits. The post-offsets are 13-bit two's-complement fractions of full scale, in units of 1/4096. They are typically used to lift black to the limited-range level: a value of 256 adds 64 output codes. After reset the matrix is the identity and all offsets are zero, so the block passes pixels through unchanged until it is programmed.

Top module: `rgb_matrix_xform`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. The matrix is the identity (diagonal entries 1.0, all others 0) and the offsets are zero, so every pixel leaves the block unchanged.
- R2: A write to coefficient address 0..8 takes cfg_wdata as a sign (bit 63) and a magnitude (bits 62:0, 32 fraction bits). The converter adds 2^19 to the magnitude and saturates the sum to 2^35-1. The stored code is the sign, then magnitude bits 34:32 as integer bits, then magnitude bits 31:20 as fraction bits.
- R3: The coefficients are indexed row by row. The R output uses addresses 0,1,2, the G output uses 3,4,5 and the B output uses 6,7,8, and within each row the three coefficients weight the R, G and B inputs in that order.
- R4: Each output channel equals floor((Σ pixel×code + offset×1024 + 2048) / 4096), where code is the signed coefficient value in units of 1/4096. In other words, three signed products are summed, the offset is added, and the result is rounded half-up to an integer code.
- R5: Addresses 9, 10 and 11 load the R, G and B post-offsets from cfg_wdata[12:0], read as two's complement. An offset of value v shifts its channel by v/4 output codes, so 256 gives +64.
- R6: A result below 0 is output as 0, and a result above 1023 is output as 1023.
- R7: When out_ready stays high, a pixel accepted in cycle t appears on the output in cycle t+3.
- R8: While out_valid is high and out_ready is low, the output data and out_valid hold steady. in_ready is low while the last stage holds a pixel and out_ready is low. No pixel is dropped or duplicated, and pixels leave in the order they arrived.
- R9: A configuration write affects only pixels accepted after the cycle of that write. A pixel accepted in the same cycle as the write, or earlier, uses the old values, even if it is still inside the pipeline.
- R10: Writes to addresses 12..15 change neither the coefficients nor the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (0..8 coefficients, 9..11 offsets) |
| cfg_wdata | input | 64 | Write data: sign-magnitude fixed point with 32 fraction bits, or an offset in bits 12:0 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_r | input | 10 | Input red |
| in_g | input | 10 | Input green |
| in_b | input | 10 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_r | output | 10 | Output red |
| out_g | output | 10 | Output green |
| out_b | output | 10 | Output blue |

## Verification
A wrong stored coefficient or offset shows up on the first pixel accepted after the faulty write, three cycles later, as a channel value that differs from the reference sum. Because the reference tracks configuration per accepted pixel, a write that leaks into a pixel already in flight is also caught on that pixel. A broken valid or stall chain shows up as a missing, duplicated or late pixel, or as a value that changes during a stall. Such faults appear within the next few handshakes, because every output transfer is compared in order against a queue of expected values.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int PIX_W   = 10;
  localparam int INT_W   = 3;
  localparam int FRAC_W  = 12;
  localparam int MAG_W   = INT_W + FRAC_W;
  localparam int COEF_W  = MAG_W + 1;
  localparam int OFF_W   = 13;
  localparam int ADDR_W  = 4;
  localparam int IN_W    = 64;
  localparam int IN_FRAC = 32;
  localparam int N_CH    = 3;
  localparam int N_COEF  = N_CH * N_CH;
  localparam int N_CFG   = N_COEF + N_CH;
  localparam int PROD_W  = PIX_W + MAG_W + 1;
  localparam int SUM_W   = PROD_W + 2;
  localparam int OFF_SHL = FRAC_W - 2;

  localparam logic [IN_W-1:0] RND_ADD = IN_W'(1) << (IN_FRAC - FRAC_W - 1);
  localparam logic [IN_W-1:0] MAG_MAX = (IN_W'(1) << (IN_FRAC + INT_W)) - IN_W'(1);
  localparam logic [COEF_W-1:0] COEF_ONE = COEF_W'(1) << FRAC_W;

  function automatic logic [COEF_W-1:0] cvt_coef(input logic [IN_W-1:0] v);
    logic [IN_W-1:0] m;
    m = {1'b0, v[IN_W-2:0]} + RND_ADD;
    if (m > MAG_MAX) m = MAG_MAX;
    return {v[IN_W-1], m[IN_FRAC+INT_W-1:IN_FRAC-FRAC_W]};
  endfunction

  function automatic logic signed [PROD_W-1:0] sm_mul(input logic [PIX_W-1:0] p,
                                                     input logic [COEF_W-1:0] c);
    logic [PIX_W+MAG_W-1:0] u;
    logic signed [PROD_W-1:0] mag;
    u   = {{MAG_W{1'b0}}, p} * {{PIX_W{1'b0}}, c[MAG_W-1:0]};
    mag = $signed({1'b0, u});
    return c[COEF_W-1] ? -mag : mag;
  endfunction

  function automatic logic [PIX_W-1:0] clamp_out(input logic signed [SUM_W-1:0] s);
    if (s[SUM_W-1]) return '0;
    if (|s[SUM_W-2:FRAC_W+PIX_W]) return '1;
    return s[FRAC_W+PIX_W-1:FRAC_W];
  endfunction
endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank
  import cmx_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [IN_W-1:0]               cfg_wdata,
  output logic [N_COEF-1:0][COEF_W-1:0] coef_q,
  output logic [N_CH-1:0][OFF_W-1:0]    off_q
);
  logic                cfg_hit;
  logic [COEF_W-1:0]   conv_w;

  assign cfg_hit = cfg_we && (cfg_addr < ADDR_W'(N_CFG));
  assign conv_w  = cvt_coef(cfg_wdata);

  for (genvar k = 0; k < N_COEF; k++) begin : g_coef
    localparam logic [COEF_W-1:0] RST_V = ((k % (N_CH + 1)) == 0) ? COEF_ONE : '0;
    logic [COEF_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_V;
      else if (cfg_we && cfg_addr == ADDR_W'(k)) r <= conv_w;
    end
    assign coef_q[k] = r;
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_off
    logic [OFF_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(N_COEF + k)) r <= cfg_wdata[OFF_W-1:0];
    end
    assign off_q[k] = r;
  end

  // R10
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_hit |=> $stable(coef_q) && $stable(off_q));

  // R2
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == '0 |=> coef_q[0][COEF_W-1] == $past(cfg_wdata[IN_W-1]));
endmodule

// File: rtl/cmx_flow.sv
module cmx_flow
  import cmx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic adv,
  output logic out_valid
);
  logic [DEPTH-1:0] v_q;
  logic             acc;
  logic [1:0]       age_q;

  assign adv       = !v_q[DEPTH-1] || out_ready;
  assign in_ready  = adv;
  assign acc       = in_valid && adv;
  assign out_valid = v_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else if (adv) v_q <= {v_q[DEPTH-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R8
  backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) && $past(acc, 3) && $past(adv, 2) && $past(adv, 1) |-> out_valid);
endmodule

// File: rtl/cmx_chan.sv
module cmx_chan
  import cmx_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic [N_CH-1:0][PIX_W-1:0]  pix,
  input  logic [N_CH-1:0][COEF_W-1:0] row,
  input  logic [OFF_W-1:0]            off,
  output logic [PIX_W-1:0]            y
);
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC_W - 1);

  logic signed [N_CH-1:0][PROD_W-1:0] p_q;
  logic signed [OFF_W-1:0]            o_q;
  logic signed [SUM_W-1:0]            s_q;
  logic signed [SUM_W-1:0]            s_d;
  logic [PIX_W-1:0]                   y_q;

  always_comb begin
    s_d = HALF + (SUM_W'(o_q) <<< OFF_SHL);
    for (int j = 0; j < N_CH; j++) s_d = s_d + SUM_W'($signed(p_q[j]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      o_q <= '0;
      s_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      for (int j = 0; j < N_CH; j++) p_q[j] <= sm_mul(pix[j], row[j]);
      o_q <= $signed(off);
      s_q <= s_d;
      y_q <= clamp_out(s_q);
    end
  end

  assign y = y_q;

  // R6
  low_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s_q[SUM_W-1] |=> y_q == '0);

  // R6
  high_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !s_q[SUM_W-1] && (|s_q[SUM_W-2:FRAC_W+PIX_W]) |=> y_q == '1);
endmodule

// File: rtl/rgb_matrix_xform.sv
module rgb_matrix_xform
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [IN_W-1:0]   cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  logic [N_COEF-1:0][COEF_W-1:0] coef_q;
  logic [N_CH-1:0][OFF_W-1:0]    off_q;
  logic [N_CH-1:0][PIX_W-1:0]    pix;
  logic [N_CH-1:0][PIX_W-1:0]    y;
  logic                          adv;

  assign pix = {in_b, in_g, in_r};

  cmx_coef_bank i_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coef_q(coef_q), .off_q(off_q)
  );

  cmx_flow #(.DEPTH(3)) i_flow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .adv(adv), .out_valid(out_valid)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cmx_chan i_chan (
      .clk(clk), .rst_n(rst_n), .adv(adv), .pix(pix),
      .row(coef_q[c*N_CH +: N_CH]), .off(off_q[c]), .y(y[c])
    );
  end

  assign out_r = y[0];
  assign out_g = y[1];
  assign out_b = y[2];

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable({out_r, out_g, out_b}));
endmodule

// File: tb/test_rgb_matrix_xform.sv
module test_rgb_matrix_xform;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [63:0] cfg_wdata = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [9:0] in_r = 0, in_g = 0, in_b = 0, out_r, out_g, out_b;

  always #2.5 clk = ~clk;

  rgb_matrix_xform i_rgb_matrix_xform (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int checks = 0, fails = 0, cyc = 0;
  int cm[9];
  int om[3];
  int q_r[$], q_g[$], q_b[$], q_t[$];
  string cur_req = "R1";
  bit chk_lat = 1, last_acc = 0, prev_stall = 0;
  logic [29:0] prev_data;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int to_code(input bit [63:0] v);
    longint unsigned m;
    int c;
    m = v & 64'h7FFF_FFFF_FFFF_FFFF;
    m = m + 64'd524288;
    if (m >= 64'h8_0000_0000) m = 64'h7_FFFF_FFFF;
    c = int'(m / 64'd1048576);
    return v[63] ? -c : c;
  endfunction

  function automatic int ref_ch(input int row, input int r, input int g, input int b);
    longint a;
    a = longint'(r) * cm[row*3] + longint'(g) * cm[row*3+1] + longint'(b) * cm[row*3+2]
        + longint'(om[row]) * 1024 + 2048;
    if (a < 0) return 0;
    a = a / 4096;
    return (a > 1023) ? 1023 : int'(a);
  endfunction

  task automatic tick();
    #1;
    cyc++;
    if (prev_stall) begin
      check(out_valid === 1'b1, "R8 valid hold", out_valid, 1);
      check({out_r, out_g, out_b} === prev_data, "R8 data hold", {out_r, out_g, out_b}, prev_data);
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = {out_r, out_g, out_b};
    if (prev_stall) check(in_ready === 1'b0, "R8 in_ready low", in_ready, 0);
    if (out_valid && out_ready) begin
      if (q_r.size() == 0) check(0, {cur_req, " unexpected pixel"}, 1, 0);
      else begin
        int er, eg, eb, et;
        er = q_r.pop_front(); eg = q_g.pop_front(); eb = q_b.pop_front(); et = q_t.pop_front();
        check(out_r == er, {cur_req, " red"}, out_r, er);
        check(out_g == eg, {cur_req, " green"}, out_g, eg);
        check(out_b == eb, {cur_req, " blue"}, out_b, eb);
        if (chk_lat) check(cyc - et == 3, "R7 latency", cyc - et, 3);
      end
    end
    last_acc = in_valid && in_ready;
    if (last_acc) begin
      q_r.push_back(ref_ch(0, in_r, in_g, in_b));
      q_g.push_back(ref_ch(1, in_r, in_g, in_b));
      q_b.push_back(ref_ch(2, in_r, in_g, in_b));
      q_t.push_back(cyc);
    end
    if (cfg_we) begin
      if (cfg_addr < 9) cm[cfg_addr] = to_code(cfg_wdata);
      else if (cfg_addr < 12) om[cfg_addr-9] = int'($signed(cfg_wdata[12:0]));
    end
    @(negedge clk);
  endtask

  task automatic send(input int r, input int g, input int b);
    in_valid = 1; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
    do tick(); while (!last_acc);
    in_valid = 0;
  endtask

  task automatic cfg(input int a, input bit [63:0] d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load_identity();
    for (int k = 0; k < 9; k++) cfg(k, (k % 4 == 0) ? 64'h1_0000_0000 : 64'h0);
    for (int k = 9; k < 12; k++) cfg(k, 64'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired, pipeline hung");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 9; k++) cm[k] = (k % 4 == 0) ? 4096 : 0;
    for (int k = 0; k < 3; k++) om[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(negedge clk);

    cur_req = "R1";
    send(100, 200, 300); send(0, 1023, 512); idle(4);

    cur_req = "R2";
    cfg(0, 64'h0000_0000_3FF8_0000); send(2, 0, 0); idle(4);
    cfg(0, 64'h0000_0000_3FF7_FFFF); send(2, 0, 0); idle(4);
    cfg(0, 64'h0000_0064_0000_0000); send(100, 0, 0); idle(4);
    cfg(0, 64'h0000_0001_0000_0000);
    cfg(1, 64'h8000_0000_8000_0000); send(600, 400, 0); idle(4);

    cur_req = "R3";
    cfg(2, 64'h0000_0000_4000_0000); cfg(6, 64'h0000_0001_0000_0000); cfg(8, 64'h0);
    send(400, 100, 800); send(7, 900, 33); idle(4);
    load_identity();

    cur_req = "R5";
    cfg(9, 64'd256); cfg(10, 64'h1F00); cfg(11, 64'd256);
    send(500, 500, 500); send(0, 10, 0); idle(4);

    cur_req = "R6";
    cfg(0, 64'h0000_0002_0000_0000); cfg(4, 64'h8000_0001_0000_0000);
    send(700, 300, 1000); idle(4);

    cur_req = "R4";
    load_identity();
    cfg(3, 64'h0000_0000_5555_5555); cfg(4, 64'h0000_0000_5555_5555); cfg(5, 64'h0000_0000_5555_5555);
    send(301, 302, 303); send(1023, 1023, 1023); idle(4);
    load_identity();

    cur_req = "R9";
    in_valid = 1; in_r = 800; in_g = 10; in_b = 20;
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 64'h0000_0000_8000_0000;
    tick(); cfg_we = 0;
    in_r = 800; tick();
    in_r = 600; cfg_we = 1; cfg_addr = 9; cfg_wdata = 64'd400; tick(); cfg_we = 0;
    in_r = 600; tick();
    in_valid = 0; idle(5);
    load_identity();

    cur_req = "R10";
    for (int a = 12; a < 16; a++) cfg(a, 64'h8000_0007_FFFF_1FFF);
    send(123, 456, 789); idle(4);

    cur_req = "R8";
    chk_lat = 0;
    out_ready = 0;
    in_valid = 1; in_r = 11; in_g = 22; in_b = 33;
    for (int i = 0; i < 6; i++) begin tick(); in_r = 10'(in_r + 1); end
    in_valid = 0; out_ready = 1; idle(6);

    for (int i = 0; i < 1500; i++) begin
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      in_r = 10'($urandom_range(0, 1023));
      in_g = 10'($urandom_range(0, 1023));
      in_b = 10'($urandom_range(0, 1023));
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_addr = 4'($urandom_range(0, 15));
      cfg_wdata = {1'($urandom_range(0, 1)), 28'd0, 3'($urandom_range(0, 1)), 32'($urandom)};
      tick();
    end
    cfg_we = 0; in_valid = 0; out_ready = 1;
    idle(8);
    check(q_r.size() == 0, "R8 all pixels delivered", q_r.size(), 0);
    finish_run();
  end
endmodule